// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for each beat of a burst into a banked cache memory. The 10-bit address holds a 2-bit bank field in its top bits and an 8-bit column below it. A burst is armed by a start pulse while the enable and select inputs are both high. On that pulse the block stores the start address and a 3-bit mode code. Each later step pulse moves it to the next address of the chosen sequence.

The mode code is read on every start, so software never loads a mode register. The code selects one of several orders: linear or interleaved wraps of 2, 4 or 8 beats, a linear sweep of one whole page, or a linear count that runs through all four banks. Lowering enable or select ends the burst at once. For writes the block raises a permit flag only while the bank field of the current address equals the bank of the open row. A second start that arrives during a live burst is refused, and the refusal is reported.

Top module: `burst_colgen`

## Requirements
- R1: After reset the block is idle: `burstActive`, `writeOk` and `restartErr` are low and `colAddr` is 0. A `startStb` pulse is taken only when the block is idle and both `burstEn` and `chipSel` are high. After the clock edge that takes it, `burstActive` is high and `colAddr` equals the captured `startAddr`.
- R2: Mode codes 3'b000, 3'b001 and 3'b010 give linear wraps of 2, 4 and 8 beats. The low log2(L) bits count up modulo L from their start value, and all higher bits keep their start value.
- R3: Mode 3'b011 counts the 8-bit column (bits 7:0) up from its start value. It wraps from 255 to 0, and the bank field (bits 9:8) never changes.
- R4: Mode 3'b111 counts the whole 10-bit address up by one per step. Column 255 of bank B is followed by column 0 of bank B+1, and address 1023 is followed by 0.
- R5: Mode codes 3'b100, 3'b101 and 3'b110 give interleaved wraps of 2, 4 and 8 beats. The low log2(L) bits equal the start offset XOR (step count modulo L), and the higher bits stay fixed. For example, a start offset of 1 with a length of 4 gives 1, 0, 3, 2.
- R6: `colAddr` advances by one position of its sequence on each clock edge that sees `stepStb` high while the burst is active. A step while idle, or in the same cycle as an accepted start, has no effect.
- R7: While `burstEn` or `chipSel` is low, `burstActive` and `writeOk` are low in that same cycle, and a step in that cycle is ignored. The burst stays ended until a new start is taken.
- R8: `writeOk` is high exactly when the burst is active and `colAddr[9:8]` equals `rowBank`.
- R9: A start pulse that arrives while a burst is active leaves the sequence unchanged. `restartErr` is high for the one cycle that follows it. A step in the same cycle still advances the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| burstEn | input | 1 | Burst enable; low ends a burst |
| chipSel | input | 1 | Device select, active high; low ends a burst |
| startStb | input | 1 | One-cycle start pulse (column latch edge) |
| stepStb | input | 1 | One-cycle advance pulse (column strobe rising) |
| startAddr | input | 10 | Start address: bank in 9:8, column in 7:0 |
| modeCode | input | 3 | Burst order and wrap length, captured on start |
| rowBank | input | 2 | Bank field of the currently open row |
| colAddr | output | 10 | Current burst address |
| burstActive | output | 1 | Burst in progress |
| writeOk | output | 1 | Write to current address permitted |
| restartErr | output | 1 | Pulse: start refused during an active burst |

## Verification
Two operations can land in the same cycle: a start and a step. The bench pulses both together in two cases. When the block is idle, the start must load and the step must be lost. When a burst is running, the start must be refused with an error pulse while the step still advances. A termination that arrives together with a step is also provoked, and the address must not move. A behavioural reference model, built from integer arithmetic on the step count, judges every cycle and compares the address, the active and permit flags, and the error pulse.

// File: rtl/burst_colgen_pkg.sv
package burst_colgen_pkg;

  typedef struct packed {
    logic load;
    logic step;
  } colStb_t;

  typedef enum logic [2:0] {
    MODE_LIN2   = 3'b000,
    MODE_LIN4   = 3'b001,
    MODE_LIN8   = 3'b010,
    MODE_PAGE   = 3'b011,
    MODE_ILV2   = 3'b100,
    MODE_ILV4   = 3'b101,
    MODE_ILV8   = 3'b110,
    MODE_ALLBNK = 3'b111
  } burstMode_e;

endpackage

// File: rtl/burst_colgen_ctl.sv
module burst_colgen_ctl
  import burst_colgen_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    burstEn,
  input  logic    chipSel,
  input  logic    startStb,
  input  logic    stepStb,
  output colStb_t stb,
  output logic    burstActive,
  output logic    restartErr
);

  logic activeQ;
  logic errQ;
  logic goOk;

  always_comb begin
    goOk     = burstEn && chipSel;
    stb.load = startStb && goOk && !activeQ;
    stb.step = stepStb && goOk && activeQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      // termination dominates; a load only happens from idle
      activeQ <= goOk && (activeQ || stb.load);
      errQ    <= startStb && goOk && activeQ;
    end
  end

  assign burstActive = activeQ && goOk;
  assign restartErr  = errQ;

endmodule

// File: rtl/burst_colgen_dp.sv
module burst_colgen_dp
  import burst_colgen_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  colStb_t           stb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [2:0]        modeCode,
  output logic [ADDR_W-1:0] colAddr,
  output logic [2:0]        curMode
);

  localparam int COL_W  = ADDR_W - BANK_W;
  localparam int N_WRAP = 3;

  logic [ADDR_W-1:0] startQ;
  logic [ADDR_W-1:0] cntQ;
  logic [2:0]        modeQ;
  logic [ADDR_W-1:0] sumAddr;
  logic [ADDR_W-1:0] pageAddr;
  logic [ADDR_W-1:0] linAddr [N_WRAP];
  logic [ADDR_W-1:0] ilvAddr [N_WRAP];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= '0;
      cntQ   <= '0;
      modeQ  <= '0;
    end else if (stb.load) begin
      startQ <= startAddr;
      modeQ  <= modeCode;
      cntQ   <= '0;
    end else if (stb.step) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  assign sumAddr  = startQ + cntQ;
  assign pageAddr = {startQ[ADDR_W-1:COL_W], sumAddr[COL_W-1:0]};

  // one candidate per wrap length, for linear and interleaved order
  for (genvar g = 0; g < N_WRAP; g++) begin : gWrap
    localparam logic [ADDR_W-1:0] WMASK = ADDR_W'((2 << g) - 1);
    assign linAddr[g] = (startQ & ~WMASK) | (sumAddr & WMASK);
    assign ilvAddr[g] = startQ ^ (cntQ & WMASK);
  end

  always_comb begin
    case (burstMode_e'(modeQ))
      MODE_LIN2:   colAddr = linAddr[0];
      MODE_LIN4:   colAddr = linAddr[1];
      MODE_LIN8:   colAddr = linAddr[2];
      MODE_PAGE:   colAddr = pageAddr;
      MODE_ILV2:   colAddr = ilvAddr[0];
      MODE_ILV4:   colAddr = ilvAddr[1];
      MODE_ILV8:   colAddr = ilvAddr[2];
      MODE_ALLBNK: colAddr = sumAddr;
      default:     colAddr = sumAddr;
    endcase
  end

  assign curMode = modeQ;

endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
  import burst_colgen_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              burstEn,
  input  logic              chipSel,
  input  logic              startStb,
  input  logic              stepStb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [2:0]        modeCode,
  input  logic [BANK_W-1:0] rowBank,
  output logic [ADDR_W-1:0] colAddr,
  output logic              burstActive,
  output logic              writeOk,
  output logic              restartErr
);

  localparam int COL_W = ADDR_W - BANK_W;

  colStb_t    stb;
  logic [2:0] curMode;

  burst_colgen_ctl i_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .burstEn     (burstEn),
    .chipSel     (chipSel),
    .startStb    (startStb),
    .stepStb     (stepStb),
    .stb         (stb),
    .burstActive (burstActive),
    .restartErr  (restartErr)
  );

  burst_colgen_dp #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .startAddr (startAddr),
    .modeCode  (modeCode),
    .colAddr   (colAddr),
    .curMode   (curMode)
  );

  assign writeOk = burstActive && (colAddr[ADDR_W-1:COL_W] == rowBank);

endmodule

// File: rtl/burst_colgen_chk.sv
module burst_colgen_chk #(
  parameter int ADDR_W = 10,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              burstEn,
  input logic              chipSel,
  input logic              startStb,
  input logic [ADDR_W-1:0] startAddr,
  input logic [ADDR_W-1:0] colAddr,
  input logic              burstActive,
  input logic              writeOk,
  input logic              restartErr,
  input logic [2:0]        curMode
);

  localparam int COL_W = ADDR_W - BANK_W;

  // R1: an accepted start presents the start address on the next cycle
  a_r1_load_addr: assert property (@(posedge clk) disable iff (!rstN)
    (startStb && burstEn && chipSel && !burstActive) |=> (colAddr == $past(startAddr)));

  // R7: termination drops activity and write permission in the same cycle
  a_r7_term_now: assert property (@(posedge clk) disable iff (!rstN)
    (!burstEn || !chipSel) |-> (!burstActive && !writeOk));

  // R9: refused start reports an error on the following cycle
  a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (startStb && burstEn && chipSel && burstActive) |=> restartErr);

  // R9: the error is only raised after a refused start
  a_r9_err_cause: assert property (@(posedge clk) disable iff (!rstN)
    restartErr |-> $past(startStb && burstActive));

  // R6: with no burst running and no start, the address holds
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!burstActive && !startStb) |=> $stable(colAddr));

  // R3: every mode except the all-bank count keeps the bank field fixed
  a_r3_bank_fixed: assert property (@(posedge clk) disable iff (!rstN)
    (burstActive && $past(burstActive) && curMode != 3'b111)
      |-> (colAddr[ADDR_W-1:COL_W] == $past(colAddr[ADDR_W-1:COL_W])));

  // R8: write permission requires an active burst
  a_r8_write_needs_burst: assert property (@(posedge clk) disable iff (!rstN)
    writeOk |-> burstActive);

endmodule

bind burst_colgen burst_colgen_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .burstEn     (burstEn),
  .chipSel     (chipSel),
  .startStb    (startStb),
  .startAddr   (startAddr),
  .colAddr     (colAddr),
  .burstActive (burstActive),
  .writeOk     (writeOk),
  .restartErr  (restartErr),
  .curMode     (curMode)
);

// File: tb/test_burst_colgen.sv
module test_burst_colgen;

  logic       clk = 1'b0;
  logic       rstN;
  logic       burstEn, chipSel, startStb, stepStb;
  logic [9:0] startAddr;
  logic [2:0] modeCode;
  logic [1:0] rowBank;
  logic [9:0] colAddr;
  logic       burstActive, writeOk, restartErr;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  // reference model state
  bit mActive;
  int mStart, mMode, mN;
  bit mErr;

  always #2 clk = ~clk;

  burst_colgen i_burst_colgen (
    .clk(clk), .rstN(rstN), .burstEn(burstEn), .chipSel(chipSel),
    .startStb(startStb), .stepStb(stepStb), .startAddr(startAddr),
    .modeCode(modeCode), .rowBank(rowBank), .colAddr(colAddr),
    .burstActive(burstActive), .writeOk(writeOk), .restartErr(restartErr)
  );

  function automatic int expAddr(int s, int m, int n);
    int len;
    case (m)
      0, 1, 2: begin len = 2 << m;       return (s / len) * len + ((s % len) + n) % len; end
      4, 5, 6: begin len = 2 << (m - 4); return (s / len) * len + ((s % len) ^ (n % len)); end
      3:       return (s / 256) * 256 + ((s % 256) + n) % 256;
      default: return (s + n) % 1024;
    endcase
  endfunction

  function automatic string modeTag(int m);
    case (m)
      0, 1, 2: return "R2";
      3:       return "R3";
      4, 5, 6: return "R5";
      default: return "R4";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mActive <= 0; mStart <= 0; mMode <= 0; mN <= 0; mErr <= 0;
    end else begin
      mErr <= startStb && burstEn && chipSel && mActive;
      if (!burstEn || !chipSel) mActive <= 0;
      else if (startStb && !mActive) begin
        mActive <= 1; mStart <= int'(startAddr); mMode <= int'(modeCode); mN <= 0;
      end else if (stepStb && mActive) mN <= mN + 1;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    bit expAct;
    int ea;
    expAct = mActive && burstEn && chipSel;
    ea = expAddr(mStart, mMode, mN);
    chk(burstActive == expAct, "R7 burstActive", int'(burstActive), int'(expAct));
    chk(restartErr == mErr, "R9 restartErr", int'(restartErr), int'(mErr));
    chk(writeOk == (expAct && (ea / 256) == int'(rowBank)), "R8 writeOk",
        int'(writeOk), int'(expAct && (ea / 256) == int'(rowBank)));
    if (expAct) chk(int'(colAddr) == ea, {modeTag(mMode), " R6 colAddr"}, int'(colAddr), ea);
  endtask

  task automatic cyc(bit be, bit cs, bit st, bit sp);
    burstEn = be; chipSel = cs; startStb = st; stepStb = sp;
    @(negedge clk);
    checkAll();
  endtask

  task automatic runBurst(int s, int m, int rb, int steps);
    startAddr = 10'(s); modeCode = 3'(m); rowBank = 2'(rb);
    cyc(1, 1, 1, 0);
    for (int i = 0; i < steps; i++) begin
      cyc(1, 1, 0, 1);
      if (i % 3 == 1) cyc(1, 1, 0, 0);
    end
    cyc(0, 1, 0, 0);
  endtask

  initial begin
    rstN = 0; burstEn = 0; chipSel = 0; startStb = 0; stepStb = 0;
    startAddr = '0; modeCode = '0; rowBank = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!burstActive && !writeOk && !restartErr, "R1 reset flags",
        int'({burstActive, writeOk, restartErr}), 0);
    chk(colAddr == 10'd0, "R1 reset colAddr", int'(colAddr), 0);
    rstN = 1;
    cyc(0, 0, 0, 0);

    // R6: step while idle, start ignored without enable (R1)
    cyc(1, 1, 0, 1);
    startAddr = 10'h155; modeCode = 3'b001;
    cyc(0, 1, 1, 0);
    cyc(1, 0, 1, 0);
    chk(colAddr == 10'd0, "R1 start without enable ignored", int'(colAddr), 0);

    // every mode with a few start offsets
    for (int m = 0; m < 8; m++) begin
      runBurst(10'h2FD, m, 2, 11);
      runBurst(10'h101, m, 1, 9);
      runBurst(10'h0F6, m, 0, 12);
    end
    // R5: start 1, length 4 -> 1,0,3,2
    runBurst(1, 5, 0, 4);
    // R4: wrap of the whole address space
    runBurst(10'h3FE, 7, 3, 4);
    // R3: full page wrap at column 255
    runBurst(10'h1FE, 3, 1, 4);

    // R9: restart during burst is refused, with and without a step
    startAddr = 10'h204; modeCode = 3'b010; rowBank = 2;
    cyc(1, 1, 1, 0);
    cyc(1, 1, 0, 1);
    startAddr = 10'h033; modeCode = 3'b111;
    cyc(1, 1, 1, 0);
    cyc(1, 1, 1, 1);
    cyc(1, 1, 0, 0);
    // R7: termination with a simultaneous step, then select drop
    cyc(0, 1, 0, 1);
    cyc(1, 1, 0, 1);
    // R6: start and step together from idle -> step lost
    startAddr = 10'h0A7; modeCode = 3'b110;
    cyc(1, 1, 1, 1);
    cyc(1, 1, 0, 1);
    cyc(1, 0, 0, 1);
    cyc(1, 1, 0, 0);
    runBurst(10'h3F0, 7, 3, 20);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule